// File: doc/BRIEF.md
# Two-Stage Proportional Frequency Quota Splitter

This block takes one aggregated frequency quota for a whole many-core chip and hands every core its own share of it. The split has two stages. In the first stage, active cores that carry the same group identifier count as one application group. Each group gets a share of the chip quota in proportion to its power efficiency. Power efficiency here is the group's summed instruction rate, divided by that application's unconstrained base rate, and then divided by the group's summed estimated power. In the second stage, each group's share is split among its member cores in proportion to a miss-weighted criticality figure. A core that misses more in its caches, and so lags its siblings, receives more of the group's frequency.

Software loads the counter snapshots and pulses a start input. The block copies all of its inputs at that instant and then runs the two stages with a single shared sequential divider, one division per group or core. When it finishes it raises a one-cycle done strobe. Idle cores take no part in either stage. They receive a zero quota and a flag asking for a low-power state. All quotas are fixed-point values in units of 1/256 of one core's peak frequency.

Top module: `qp_partitioner`

## Requirements
- R1: Every input is captured at the start pulse that is accepted while the block is idle. Input changes and further start pulses while busy do not affect the results of the run in progress, and no new run begins.
- R2: A group is the set of non-idle cores whose group identifier matches. The group's base rate is the base register of its lowest-indexed member core.
- R3: Group efficiency is floor(summed rate × 1024 / (base rate × summed power)). It is 0 when base rate × summed power is 0.
- R4: An existing group's quota is floor(chip quota × group efficiency / sum of all group efficiencies).
- R5: When the efficiencies of all groups sum to 0, each existing group's quota is floor(chip quota / number of existing groups).
- R6: Core criticality is (misses hitting the second-level cache) × 10 + (misses going to memory) × 200. A core's raw quota is floor(group quota × criticality / criticality summed over its group).
- R7: When a group's criticality sum is 0, each member's raw quota is floor(group quota / member count). A single-member group passes its whole group quota to its core.
- R8: A non-idle core's output quota is its raw quota clamped to the range 179 to 256.
- R9: An idle core's output quota is 0 and its low-power flag is 1. A non-idle core's flag is 0.
- R10: After reset, busy, done, every quota and every flag are 0. Busy is 1 from the cycle after an accepted start until the completion cycle. Done is a single-cycle pulse in that completion cycle, during which busy is 0 and all outputs are final.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a partitioning run (accepted when idle) |
| chip_quota_i | input | 11 | Aggregated chip quota, 1/256 peak units |
| core_idle_i | input | 4 | Per-core idle indication |
| core_group_i | input | 4×2 | Per-core application group identifier |
| core_ips_i | input | 4×12 | Per-core measured instruction rate |
| core_power_i | input | 4×12 | Per-core estimated power |
| base_ips_i | input | 4×12 | Per-core unconstrained base rate of its application |
| miss_l2hit_i | input | 4×12 | Per-core first-level misses served by the second level |
| miss_mem_i | input | 4×12 | Per-core misses in both cache levels |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Single-cycle completion strobe |
| core_quota_o | output | 4×9 | Per-core frequency quota, 1/256 peak units |
| low_power_o | output | 4 | Per-core low-power request |

## Verification
The hardest situation to reach from the ports is one where the proportional division is bypassed: efficiencies that sum to exactly zero, or a group whose criticality sum is zero while other groups are normal. Random counters almost never produce these cases. The stimulus therefore mixes random runs with directed ones. The directed runs zero every power input to force the even split across groups, zero the miss counters of one multi-core group, and zero one group's base register so that its efficiency falls to zero. The snapshot rule is driven by changing all inputs and pulsing start again partway through a run, and the results must still match the first input set.

// File: rtl/qp_pkg.sv
package qp_pkg;
  typedef enum logic [1:0] {PH_EFF, PH_GRP, PH_CORE} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} state_e;
endpackage

// File: rtl/qp_crit.sv
module qp_crit #(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 12,
  parameter int CRIT_W    = 21,
  parameter int L1_PEN    = 10,
  parameter int L2_PEN    = 200
) (
  input  logic [NUM_CORES-1:0][CNT_W-1:0]  l2hit_i,
  input  logic [NUM_CORES-1:0][CNT_W-1:0]  mem_i,
  output logic [NUM_CORES-1:0][CRIT_W-1:0] crit_o
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign crit_o[c] = CRIT_W'(l2hit_i[c]) * CRIT_W'(L1_PEN)
                     + CRIT_W'(mem_i[c])   * CRIT_W'(L2_PEN);
  end
endmodule

// File: rtl/qp_group_sum.sv
module qp_group_sum #(
  parameter int NUM_CORES = 4,
  parameter int NUM_GRP   = 4,
  parameter int GID_W     = 2,
  parameter int CNT_W     = 12,
  parameter int SUM_W     = 15,
  parameter int CRIT_W    = 21,
  parameter int CSUM_W    = 24,
  parameter int MEM_W     = 3
) (
  input  logic [NUM_CORES-1:0]             idle_i,
  input  logic [NUM_CORES-1:0][GID_W-1:0]  gid_i,
  input  logic [NUM_CORES-1:0][CNT_W-1:0]  ips_i,
  input  logic [NUM_CORES-1:0][CNT_W-1:0]  pwr_i,
  input  logic [NUM_CORES-1:0][CNT_W-1:0]  base_i,
  input  logic [NUM_CORES-1:0][CRIT_W-1:0] crit_i,
  output logic [NUM_GRP-1:0]               exists_o,
  output logic [NUM_GRP-1:0][SUM_W-1:0]    ips_sum_o,
  output logic [NUM_GRP-1:0][SUM_W-1:0]    pwr_sum_o,
  output logic [NUM_GRP-1:0][CNT_W-1:0]    base_o,
  output logic [NUM_GRP-1:0][CSUM_W-1:0]   crit_sum_o,
  output logic [NUM_GRP-1:0][MEM_W-1:0]    members_o
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    always_comb begin
      exists_o[g]   = 1'b0;
      ips_sum_o[g]  = '0;
      pwr_sum_o[g]  = '0;
      base_o[g]     = '0;
      crit_sum_o[g] = '0;
      members_o[g]  = '0;
      // descending scan: the lowest-index member sets the base rate last
      for (int c = NUM_CORES - 1; c >= 0; c--) begin
        if (!idle_i[c] && gid_i[c] == GID_W'(g)) begin
          exists_o[g]   = 1'b1;
          ips_sum_o[g]  = ips_sum_o[g] + SUM_W'(ips_i[c]);
          pwr_sum_o[g]  = pwr_sum_o[g] + SUM_W'(pwr_i[c]);
          base_o[g]     = base_i[c];
          crit_sum_o[g] = crit_sum_o[g] + CSUM_W'(crit_i[c]);
          members_o[g]  = members_o[g] + MEM_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/qp_divider.sv
module qp_divider #(
  parameter int W = 37
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     q_q, n_q, d_q, rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W:0]       trial, diff;
  logic             fits;

  assign trial = {rem_q, q_q[W-1]};
  assign diff  = trial - {1'b0, d_q};
  assign fits  = trial >= {1'b0, d_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0; n_q <= '0; d_q <= '0; rem_q <= '0;
      cnt_q <= '0; busy_o <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        q_q    <= dividend_i;
        n_q    <= dividend_i;
        d_q    <= divisor_i;
        rem_q  <= '0;
        cnt_q  <= CNT_W'(W);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
        q_q   <= {q_q[W-2:0], fits};
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = q_q;

  logic [2*W-1:0] prod;
  assign prod = {{W{1'b0}}, q_q} * {{W{1'b0}}, d_q};

  // R4: every issued division delivers the floor quotient
  a_r4_div_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (prod <= {{W{1'b0}}, n_q}) && ({{W{1'b0}}, n_q} - prod < {{W{1'b0}}, d_q}));
endmodule

// File: rtl/qp_partitioner.sv
module qp_partitioner
  import qp_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 12,
  parameter int PEN_W     = 8,
  parameter int L1_PEN    = 10,
  parameter int L2_PEN    = 200,
  parameter int FRAC_W    = 8,
  parameter int LOW_Q     = 179,
  parameter int EFF_SH    = 10,
  parameter int GID_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  parameter int QUOTA_W   = FRAC_W + 1 + GID_W,
  parameter int OUT_W     = FRAC_W + 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic [QUOTA_W-1:0]              chip_quota_i,
  input  logic [NUM_CORES-1:0]            core_idle_i,
  input  logic [NUM_CORES-1:0][GID_W-1:0] core_group_i,
  input  logic [NUM_CORES-1:0][CNT_W-1:0] core_ips_i,
  input  logic [NUM_CORES-1:0][CNT_W-1:0] core_power_i,
  input  logic [NUM_CORES-1:0][CNT_W-1:0] base_ips_i,
  input  logic [NUM_CORES-1:0][CNT_W-1:0] miss_l2hit_i,
  input  logic [NUM_CORES-1:0][CNT_W-1:0] miss_mem_i,
  output logic                            busy_o,
  output logic                            done_o,
  output logic [NUM_CORES-1:0][OUT_W-1:0] core_quota_o,
  output logic [NUM_CORES-1:0]            low_power_o
);
  localparam int NUM_GRP = 1 << GID_W;
  localparam int ONE     = 1 << FRAC_W;
  localparam int CL      = GID_W + 1;
  localparam int SUM_W   = CNT_W + CL;
  localparam int EFF_W   = SUM_W + EFF_SH;
  localparam int ESUM_W  = EFF_W + CL;
  localparam int CRIT_W  = CNT_W + PEN_W + 1;
  localparam int CSUM_W  = CRIT_W + CL;
  localparam int MEM_W   = CL;
  localparam int DIV_W   = QUOTA_W + EFF_W + 1;

  // snapshot of all inputs
  logic [QUOTA_W-1:0]              quota_q;
  logic [NUM_CORES-1:0]            idle_q;
  logic [NUM_CORES-1:0][GID_W-1:0] gid_q;
  logic [NUM_CORES-1:0][CNT_W-1:0] ips_q, pwr_q, base_q, m1_q, m2_q;

  state_e st_q;
  phase_e ph_q;
  logic [GID_W-1:0] idx_q;

  logic [NUM_GRP-1:0][EFF_W-1:0]   eff_q;
  logic [NUM_GRP-1:0][QUOTA_W-1:0] gq_q;

  logic [NUM_CORES-1:0][CRIT_W-1:0] crit;
  logic [NUM_GRP-1:0]               grp_ex;
  logic [NUM_GRP-1:0][SUM_W-1:0]    ips_sum, pwr_sum;
  logic [NUM_GRP-1:0][CNT_W-1:0]    base_sel;
  logic [NUM_GRP-1:0][CSUM_W-1:0]   crit_sum;
  logic [NUM_GRP-1:0][MEM_W-1:0]    members;

  qp_crit #(
    .NUM_CORES(NUM_CORES), .CNT_W(CNT_W), .CRIT_W(CRIT_W),
    .L1_PEN(L1_PEN), .L2_PEN(L2_PEN)
  ) i_crit (
    .l2hit_i(m1_q), .mem_i(m2_q), .crit_o(crit)
  );

  qp_group_sum #(
    .NUM_CORES(NUM_CORES), .NUM_GRP(NUM_GRP), .GID_W(GID_W), .CNT_W(CNT_W),
    .SUM_W(SUM_W), .CRIT_W(CRIT_W), .CSUM_W(CSUM_W), .MEM_W(MEM_W)
  ) i_group_sum (
    .idle_i(idle_q), .gid_i(gid_q), .ips_i(ips_q), .pwr_i(pwr_q),
    .base_i(base_q), .crit_i(crit),
    .exists_o(grp_ex), .ips_sum_o(ips_sum), .pwr_sum_o(pwr_sum),
    .base_o(base_sel), .crit_sum_o(crit_sum), .members_o(members)
  );

  // totals over groups
  logic [ESUM_W-1:0] esum;
  logic [MEM_W-1:0]  n_grp;
  always_comb begin
    esum  = '0;
    n_grp = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      esum = esum + ESUM_W'(eff_q[g]);
      if (grp_ex[g]) n_grp = n_grp + MEM_W'(1);
    end
  end

  // operand selection for the shared divider
  logic [GID_W-1:0] g_sel;
  logic [DIV_W-1:0] num, den;
  logic             skip;
  always_comb begin
    g_sel = (ph_q == PH_CORE) ? gid_q[idx_q] : idx_q;
    num   = '0;
    den   = '0;
    skip  = 1'b1;
    case (ph_q)
      PH_EFF: begin
        num  = DIV_W'(ips_sum[g_sel]) << EFF_SH;
        den  = DIV_W'(base_sel[g_sel]) * DIV_W'(pwr_sum[g_sel]);
        skip = !grp_ex[g_sel] || (den == '0);
      end
      PH_GRP: begin
        num  = DIV_W'(quota_q) * ((esum == '0) ? DIV_W'(1) : DIV_W'(eff_q[g_sel]));
        den  = (esum == '0) ? DIV_W'(n_grp) : DIV_W'(esum);
        skip = !grp_ex[g_sel];
      end
      PH_CORE: begin
        num  = DIV_W'(gq_q[g_sel]) *
               ((crit_sum[g_sel] == '0) ? DIV_W'(1) : DIV_W'(crit[idx_q]));
        den  = (crit_sum[g_sel] == '0) ? DIV_W'(members[g_sel]) : DIV_W'(crit_sum[g_sel]);
        skip = idle_q[idx_q];
      end
      default: ;
    endcase
  end

  logic             div_start, div_busy, div_done;
  logic [DIV_W-1:0] div_quot;

  assign div_start = (st_q == ST_ISSUE) && !skip;

  qp_divider #(.W(DIV_W)) i_divider (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start),
    .dividend_i(num), .divisor_i(den),
    .busy_o(div_busy), .done_o(div_done), .quot_o(div_quot)
  );

  logic             wr_en, last;
  logic [DIV_W-1:0] wr_val;
  logic [OUT_W-1:0] clamped;

  assign wr_en  = ((st_q == ST_ISSUE) && skip) || ((st_q == ST_WAIT) && div_done);
  assign wr_val = (st_q == ST_WAIT) ? div_quot : '0;
  assign last   = (ph_q == PH_CORE) ? (idx_q == GID_W'(NUM_CORES - 1))
                                    : (idx_q == GID_W'(NUM_GRP - 1));

  always_comb begin
    if (wr_val > DIV_W'(ONE))        clamped = OUT_W'(ONE);
    else if (wr_val < DIV_W'(LOW_Q)) clamped = OUT_W'(LOW_Q);
    else                             clamped = wr_val[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; ph_q <= PH_EFF; idx_q <= '0;
      quota_q <= '0; idle_q <= '0; gid_q <= '0;
      ips_q <= '0; pwr_q <= '0; base_q <= '0; m1_q <= '0; m2_q <= '0;
      eff_q <= '0; gq_q <= '0;
      core_quota_o <= '0; low_power_o <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          quota_q <= chip_quota_i; idle_q <= core_idle_i; gid_q <= core_group_i;
          ips_q <= core_ips_i; pwr_q <= core_power_i; base_q <= base_ips_i;
          m1_q <= miss_l2hit_i; m2_q <= miss_mem_i;
          ph_q <= PH_EFF; idx_q <= '0; st_q <= ST_ISSUE;
        end
        ST_ISSUE: if (!skip) st_q <= ST_WAIT;
        default: ;
      endcase
      if (wr_en) begin
        case (ph_q)
          PH_EFF: eff_q[g_sel] <= EFF_W'(wr_val);
          PH_GRP: gq_q[g_sel]  <= QUOTA_W'(wr_val);
          default: begin
            core_quota_o[idx_q] <= idle_q[idx_q] ? '0 : clamped;
            low_power_o[idx_q]  <= idle_q[idx_q];
          end
        endcase
        st_q <= ST_ISSUE;
        if (last) begin
          idx_q <= '0;
          case (ph_q)
            PH_EFF: ph_q <= PH_GRP;
            PH_GRP: ph_q <= PH_CORE;
            default: begin
              st_q   <= ST_IDLE;
              done_o <= 1'b1;
            end
          endcase
        end else begin
          idx_q <= idx_q + GID_W'(1);
        end
      end
    end
  end

  assign busy_o = (st_q != ST_IDLE);

  a_r1_snapshot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(quota_q) && $stable(idle_q) && $stable(gid_q) && $stable(ips_q));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r10_one_division: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_start |-> !div_busy);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    a_r8_clamp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !low_power_o[c]) |->
        (core_quota_o[c] >= OUT_W'(LOW_Q)) && (core_quota_o[c] <= OUT_W'(ONE)));
    a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && low_power_o[c]) |-> (core_quota_o[c] == '0));
  end
endmodule

// File: tb/test_qp_partitioner.sv
module test_qp_partitioner;
  localparam int NC = 4, CW = 12, GW = 2, QW = 11, OW = 9;
  localparam int L1P = 10, L2P = 200, LOWQ = 179, ONEQ = 256, ESH = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk; // 4 time units: 250 MHz with 1 ns units

  logic                    start = 1'b0;
  logic [QW-1:0]           quota = '0;
  logic [NC-1:0]           idle = '0;
  logic [NC-1:0][GW-1:0]   grp = '0;
  logic [NC-1:0][CW-1:0]   ips = '0, pwr = '0, bips = '0, m1 = '0, m2 = '0;
  logic                    busy, done;
  logic [NC-1:0][OW-1:0]   cq;
  logic [NC-1:0]           lp;

  int n_run = 0, n_fail = 0;
  longint exp_q[NC];
  int     exp_lp[NC];

  qp_partitioner i_qp_partitioner (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chip_quota_i(quota),
    .core_idle_i(idle), .core_group_i(grp), .core_ips_i(ips), .core_power_i(pwr),
    .base_ips_i(bips), .miss_l2hit_i(m1), .miss_mem_i(m2),
    .busy_o(busy), .done_o(done), .core_quota_o(cq), .low_power_o(lp)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model();
    longint eff[NC], gq[NC], cs[NC];
    int     ex[NC], mem[NC];
    longint esum = 0;
    int     ng = 0;
    for (int g = 0; g < NC; g++) begin
      longint is = 0, ps = 0, bs = 0;
      int found = 0;
      ex[g] = 0; mem[g] = 0; cs[g] = 0;
      for (int c = 0; c < NC; c++) begin
        if (!idle[c] && int'(grp[c]) == g) begin
          ex[g] = 1; mem[g]++;
          is += ips[c]; ps += pwr[c];
          cs[g] += longint'(m1[c]) * L1P + longint'(m2[c]) * L2P;
          if (found == 0) begin bs = bips[c]; found = 1; end
        end
      end
      eff[g] = (ex[g] != 0 && bs * ps != 0) ? ((is << ESH) / (bs * ps)) : 0;
      esum += eff[g];
      ng += ex[g];
    end
    for (int g = 0; g < NC; g++) begin
      if (ex[g] == 0)     gq[g] = 0;
      else if (esum == 0) gq[g] = longint'(quota) / ng;
      else                gq[g] = longint'(quota) * eff[g] / esum;
    end
    for (int c = 0; c < NC; c++) begin
      if (idle[c]) begin
        exp_q[c] = 0; exp_lp[c] = 1;
      end else begin
        int g = int'(grp[c]);
        longint cr = longint'(m1[c]) * L1P + longint'(m2[c]) * L2P;
        longint v = (cs[g] == 0) ? gq[g] / mem[g] : gq[g] * cr / cs[g];
        if (v > ONEQ) v = ONEQ;
        if (v < LOWQ) v = LOWQ;
        exp_q[c] = v; exp_lp[c] = 0;
      end
    end
  endtask

  task automatic launch();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10", "busy after start", busy, 1);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    if (!done) chk("R10", "watchdog on done", 0, 1);
  endtask

  task automatic compare(string tag);
    for (int c = 0; c < NC; c++) begin
      chk(tag, $sformatf("quota core %0d", c), cq[c], exp_q[c]);
      chk("R9", $sformatf("low power core %0d", c), lp[c], exp_lp[c]);
    end
    chk("R10", "busy low at done", busy, 0);
  endtask

  task automatic run(string tag);
    model();
    launch();
    wait_done();
    compare(tag);
  endtask

  task automatic uniform(int q);
    quota = QW'(q);
    for (int c = 0; c < NC; c++) begin
      idle[c] = 1'b0; grp[c] = GW'(c);
      ips[c] = 12'd1000; pwr[c] = 12'd100; bips[c] = 12'd1000;
      m1[c] = 12'd50; m2[c] = 12'd5;
    end
  endtask

  task automatic randomize_inputs();
    quota = QW'($urandom % 1200);
    for (int c = 0; c < NC; c++) begin
      idle[c] = ($urandom % 4 == 0);
      grp[c]  = GW'($urandom % NC);
      ips[c]  = CW'($urandom % 4096);
      pwr[c]  = ($urandom % 8 == 0) ? '0 : CW'($urandom % 4096);
      bips[c] = ($urandom % 10 == 0) ? '0 : CW'(1 + $urandom % 4095);
      m1[c]   = ($urandom % 6 == 0) ? '0 : CW'($urandom % 4096);
      m2[c]   = ($urandom % 6 == 0) ? '0 : CW'($urandom % 512);
    end
  endtask

  initial begin
    #800000;
    n_run++; n_fail++;
    $display("FAIL R10 global watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R10", "reset busy", busy, 0);
    chk("R10", "reset done", done, 0);
    chk("R10", "reset quotas", cq, 0);
    chk("R10", "reset flags", lp, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3, R4: four single-core groups with efficiencies 10, 9, 8, 9
    uniform(864);
    ips[1] = 12'd900; ips[2] = 12'd800; ips[3] = 12'd900;
    run("R4");
    chk("R3", "core 0 share", cq[0], 240);
    chk("R4", "core 2 share", cq[2], 192);

    // R3: zero base rate zeroes one group's efficiency
    uniform(600);
    bips[3] = '0;
    run("R3");

    // R5: all powers zero -> even split over groups
    uniform(800);
    for (int c = 0; c < NC; c++) pwr[c] = '0;
    run("R5");
    chk("R5", "even group split", cq[1], 200);

    // R7: zero criticality in a three-core group, single-core group beside it
    uniform(1000);
    grp[1] = 2'd0; grp[2] = 2'd0;
    m1[0] = '0; m2[0] = '0; m1[1] = '0; m2[1] = '0; m1[2] = '0; m2[2] = '0;
    run("R7");

    // R6: criticality split within one four-core group
    uniform(900);
    for (int c = 0; c < NC; c++) grp[c] = 2'd1;
    m1[0] = 12'd10; m2[0] = 12'd1; m1[1] = 12'd40; m2[1] = 12'd2;
    m1[2] = 12'd0;  m2[2] = 12'd3; m1[3] = 12'd30; m2[3] = 12'd0;
    run("R6");

    // R2: shared group, lowest-index member supplies the base rate
    uniform(700);
    grp[0] = 2'd2; grp[2] = 2'd2; idle[1] = 1'b1;
    bips[0] = 12'd500; bips[2] = 12'd3000; ips[2] = 12'd2000;
    run("R2");

    // R8: zero quota -> low clamp; huge share -> high clamp
    uniform(0);
    run("R8");
    uniform(1200);
    idle[1] = 1'b1; idle[2] = 1'b1; idle[3] = 1'b1;
    run("R8");
    chk("R8", "high clamp", cq[0], ONEQ);

    // R9: every core idle
    uniform(500);
    idle = '1;
    run("R9");

    // R1: inputs and start changed mid-run are ignored
    uniform(864);
    ips[1] = 12'd900; ips[2] = 12'd800; ips[3] = 12'd900;
    model();
    launch();
    repeat (10) @(negedge clk);
    quota = QW'(100); idle = 4'b0101; grp = '0; ips = '0; pwr = '0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    compare("R1");
    repeat (3) @(negedge clk);
    chk("R1", "no second run", busy, 0);

    for (int i = 0; i < 150; i++) begin
      randomize_inputs();
      run("R6");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule